// File: doc/BRIEF.md
# Threshold-Gated Survivor Memory

This block is the survivor memory of a 16-state, rate-1/3, constraint-length-5 trellis decoder. It uses register exchange, and it cuts register switching by letting only promising states take part. In each trellis stage the block takes the sixteen path metrics and the sixteen add-compare-select decision bits. A state joins the exchange only if its path metric does not exceed a threshold. The threshold is set from the code's free distance, which bounds how many errors the decoder can still correct. States above the threshold are neither written nor read as sources. The block therefore never keeps one register per state. It keeps a pool of eight tagged slots, half the state count, and each slot holds a state tag, a valid flag and a 16-bit decoded path.

At the start of each frame the trellis is assumed to sit in state 0. Pulsing `frame_start` puts one valid, empty path in state 0 and latches the threshold for the whole frame. After every stage, the read port shows the path currently held for state 0. Once the frame has been driven back to state 0, that path is the decoded data. The block also reports how many slot path registers were loaded in the last stage, so the switching saving can be measured from outside.

Top module: `tm_survivor_mem`

## Requirements
- R1: After reset, and in the cycle after `frame_start`, `s0_valid` is 1, `s0_path` is 0 and `path_loads` is 0. No other state holds a path at that point.
- R2: A state s qualifies in a stage when its unsigned metric `path_metrics[s*8 +: 8]` is less than or equal to the active threshold. A metric equal to the threshold qualifies, and a metric one above it does not.
- R3: The predecessor of a qualifying state s is `{decisions[s], s[3:1]}`. When that predecessor holds a valid path P, the new path of s is `{P[14:0], s[0]}`.
- R4: When the predecessor of a qualifying state holds no valid path, that state ends the stage without a valid path.
- R5: A state that does not qualify in a stage holds no valid path after that stage. In particular, state 0 with a metric above the threshold gives `s0_valid` = 0.
- R6: At most 8 states keep a path per stage. Qualifying states are admitted in ascending state number, and any beyond the eighth are dropped as if excluded.
- R7: In the cycle after an accepted stage, `path_loads` equals the number of states whose path was loaded from a valid predecessor. In the cycle after any other clock edge it is 0.
- R8: The active threshold is 5 after reset. It takes the value of `threshold` only on a `frame_start` edge, and changes on `threshold` at any other time have no effect.
- R9: When `frame_start` and `stage_valid` are both high, the frame restart wins and the stage is ignored.
- R10: At a clock edge with neither `stage_valid` nor `frame_start`, `s0_valid` and `s0_path` do not change, whatever the metric and decision inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Restart the trellis in state 0 and latch the threshold |
| stage_valid | input | 1 | Metrics and decisions of one trellis stage are present |
| threshold | input | 4 | Threshold to be latched at the next frame start |
| path_metrics | input | 128 | Sixteen 8-bit path metrics; state s sits at bits s*8+7 down to s*8 |
| decisions | input | 16 | Decision bit of state s at bit s |
| s0_path | output | 16 | Decoded path currently held for state 0, newest bit at bit 0 |
| s0_valid | output | 1 | State 0 holds a valid path |
| path_loads | output | 4 | Slot path registers loaded in the previous stage |

## Verification
The bench attacks the threshold boundary: a metric equal to the threshold must pass, and a comparison with the wrong sense would either drop state 0 or keep it one level too long. It fills all sixteen states so that the slot pool overflows. A design that admits states in descending order, or does not cap at eight, then reports the wrong load count, or later revives a state that should have been dropped. It drives a hand-built walk 0→1→2→4→8→0 whose only correct path is 0x0010, which exposes a wrong predecessor formula or a wrong bit order. It also changes the threshold in the middle of a frame and pulses restart together with a stage. A design that reads the threshold live, or lets the stage win, shows state 0 in the wrong condition.

// File: rtl/svm_pkg.sv
`timescale 1ns/1ps
package svm_pkg;

  localparam int SVM_MEMORY    = 4;
  localparam int SVM_SLOTS     = 8;
  localparam int SVM_PATH_LEN  = 16;
  localparam int SVM_METRIC_W  = 8;
  localparam int SVM_THR_W     = 4;
  localparam int SVM_THR_INIT  = 5;

  // State that feeds 'state' when the survivor decision is 'dbit'.
  function automatic int pred_state(input int state, input logic dbit, input int mem);
    return (int'(dbit) << (mem - 1)) | (state >> 1);
  endfunction

  // Qualification rule: at or below the threshold.
  function automatic logic within_limit(input int metric, input int thr);
    return (metric <= thr);
  endfunction

endpackage

// File: rtl/svm_slot_alloc.sv
`timescale 1ns/1ps
module svm_slot_alloc #(
  parameter int NUM_STATES = 16,
  parameter int NUM_SLOTS  = 8,
  parameter int METRIC_W   = 8,
  parameter int THR_W      = 4,
  parameter int STATE_W    = 4
) (
  input  logic [NUM_STATES-1:0][METRIC_W-1:0] metrics,
  input  logic [THR_W-1:0]                    thr,
  output logic [NUM_STATES-1:0]               qual_vec,
  output logic [NUM_STATES-1:0]               dropped,
  output logic [NUM_SLOTS-1:0]                claim,
  output logic [NUM_SLOTS-1:0][STATE_W-1:0]   claim_tag
);

  localparam int RANK_W = $clog2(NUM_STATES + 1);

  logic [NUM_STATES-1:0][RANK_W-1:0] rank;

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
    localparam logic [NUM_STATES-1:0] BELOW = NUM_STATES'((64'd1 << s) - 64'd1);
    assign qual_vec[s] = svm_pkg::within_limit(int'(metrics[s]), int'(thr));
    assign rank[s]     = RANK_W'($countones(qual_vec & BELOW));
    assign dropped[s]  = qual_vec[s] && (int'(rank[s]) >= NUM_SLOTS);
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    always_comb begin
      claim[k]     = 1'b0;
      claim_tag[k] = '0;
      for (int s = 0; s < NUM_STATES; s++) begin
        if (qual_vec[s] && (int'(rank[s]) == k)) begin
          claim[k]     = 1'b1;
          claim_tag[k] = STATE_W'(s);
        end
      end
    end
  end

endmodule

// File: rtl/svm_src_match.sv
`timescale 1ns/1ps
module svm_src_match #(
  parameter int NUM_STATES = 16,
  parameter int NUM_SLOTS  = 8,
  parameter int PATH_LEN   = 16,
  parameter int STATE_W    = 4
) (
  input  logic [NUM_SLOTS-1:0][STATE_W-1:0]  claim_tag,
  input  logic [NUM_STATES-1:0]              decisions,
  input  logic [NUM_SLOTS-1:0]               cur_valid,
  input  logic [NUM_SLOTS-1:0][STATE_W-1:0]  cur_tag,
  input  logic [NUM_SLOTS-1:0][PATH_LEN-1:0] cur_path,
  output logic [NUM_SLOTS-1:0]               src_hit,
  output logic [NUM_SLOTS-1:0][PATH_LEN-1:0] new_path
);

  function automatic logic [PATH_LEN-1:0] extend_path(input logic [PATH_LEN-1:0] p,
                                                      input logic bit_in);
    return {p[PATH_LEN-2:0], bit_in};
  endfunction

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic               dbit;
    logic [STATE_W-1:0] pred_tag;
    logic [PATH_LEN-1:0] src_path;

    assign dbit     = decisions[claim_tag[k]];
    assign pred_tag = STATE_W'(svm_pkg::pred_state(int'(claim_tag[k]), dbit, STATE_W));

    always_comb begin
      src_hit[k] = 1'b0;
      src_path   = '0;
      for (int j = 0; j < NUM_SLOTS; j++) begin
        if (cur_valid[j] && (cur_tag[j] == pred_tag)) begin
          src_hit[k] = 1'b1;
          src_path   = cur_path[j];
        end
      end
    end

    assign new_path[k] = extend_path(src_path, claim_tag[k][0]);
  end

endmodule

// File: rtl/svm_slot_bank.sv
`timescale 1ns/1ps
module svm_slot_bank #(
  parameter int NUM_SLOTS = 8,
  parameter int PATH_LEN  = 16,
  parameter int STATE_W   = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               init,
  input  logic                               update,
  input  logic [NUM_SLOTS-1:0]               claim,
  input  logic [NUM_SLOTS-1:0][STATE_W-1:0]  claim_tag,
  input  logic [NUM_SLOTS-1:0]               src_hit,
  input  logic [NUM_SLOTS-1:0][PATH_LEN-1:0] new_path,
  output logic [NUM_SLOTS-1:0]               slot_valid,
  output logic [NUM_SLOTS-1:0][STATE_W-1:0]  slot_tag,
  output logic [NUM_SLOTS-1:0][PATH_LEN-1:0] slot_path
);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic START_VALID = (k == 0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[k] <= START_VALID;
        slot_tag[k]   <= '0;
        slot_path[k]  <= '0;
      end else if (init) begin
        slot_valid[k] <= START_VALID;
        if (START_VALID) begin
          slot_tag[k]  <= '0;
          slot_path[k] <= '0;
        end
      end else if (update) begin
        if (claim[k]) begin
          slot_tag[k]   <= claim_tag[k];
          slot_valid[k] <= src_hit[k];
          if (src_hit[k]) slot_path[k] <= new_path[k];
        end else begin
          slot_valid[k] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/svm_s0_read.sv
`timescale 1ns/1ps
module svm_s0_read #(
  parameter int NUM_SLOTS = 8,
  parameter int PATH_LEN  = 16,
  parameter int STATE_W   = 4
) (
  input  logic [NUM_SLOTS-1:0]               slot_valid,
  input  logic [NUM_SLOTS-1:0][STATE_W-1:0]  slot_tag,
  input  logic [NUM_SLOTS-1:0][PATH_LEN-1:0] slot_path,
  output logic                               hit,
  output logic [PATH_LEN-1:0]                path
);

  always_comb begin
    hit  = 1'b0;
    path = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (slot_valid[k] && (slot_tag[k] == '0)) begin
        hit  = 1'b1;
        path = slot_path[k];
      end
    end
  end

endmodule

// File: rtl/tm_survivor_mem.sv
`timescale 1ns/1ps
module tm_survivor_mem #(
  parameter int MEMORY   = svm_pkg::SVM_MEMORY,
  parameter int NUM_SLOTS = svm_pkg::SVM_SLOTS,
  parameter int PATH_LEN = svm_pkg::SVM_PATH_LEN,
  parameter int METRIC_W = svm_pkg::SVM_METRIC_W,
  parameter int THR_W    = svm_pkg::SVM_THR_W,
  parameter int THR_INIT = svm_pkg::SVM_THR_INIT,
  localparam int NUM_STATES = 1 << MEMORY,
  localparam int LOAD_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_start,
  input  logic                           stage_valid,
  input  logic [THR_W-1:0]               threshold,
  input  logic [NUM_STATES*METRIC_W-1:0] path_metrics,
  input  logic [NUM_STATES-1:0]          decisions,
  output logic [PATH_LEN-1:0]            s0_path,
  output logic                           s0_valid,
  output logic [LOAD_W-1:0]              path_loads
);

  localparam int STATE_W = MEMORY;

  logic [NUM_STATES-1:0][METRIC_W-1:0] metric_arr;
  logic [THR_W-1:0]                    thr_active;
  logic                                stage_take;
  logic [NUM_STATES-1:0]               qual_vec;
  logic [NUM_STATES-1:0]               dropped_vec;
  logic [NUM_SLOTS-1:0]                claim_vec;
  logic [NUM_SLOTS-1:0][STATE_W-1:0]   claim_tag;
  logic [NUM_SLOTS-1:0]                src_hit;
  logic [NUM_SLOTS-1:0][PATH_LEN-1:0]  new_path;
  logic [NUM_SLOTS-1:0]                slot_valid;
  logic [NUM_SLOTS-1:0][STATE_W-1:0]   slot_tag;
  logic [NUM_SLOTS-1:0][PATH_LEN-1:0]  slot_path;
  logic [NUM_SLOTS-1:0]                load_vec;

  assign metric_arr = path_metrics;
  assign stage_take = stage_valid && !frame_start;
  assign load_vec   = claim_vec & src_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           thr_active <= THR_W'(THR_INIT);
    else if (frame_start) thr_active <= threshold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          path_loads <= '0;
    else if (stage_take) path_loads <= LOAD_W'($countones(load_vec));
    else                 path_loads <= '0;
  end

  svm_slot_alloc #(
    .NUM_STATES(NUM_STATES), .NUM_SLOTS(NUM_SLOTS), .METRIC_W(METRIC_W),
    .THR_W(THR_W), .STATE_W(STATE_W)
  ) u_alloc (
    .metrics  (metric_arr),
    .thr      (thr_active),
    .qual_vec (qual_vec),
    .dropped  (dropped_vec),
    .claim    (claim_vec),
    .claim_tag(claim_tag)
  );

  svm_src_match #(
    .NUM_STATES(NUM_STATES), .NUM_SLOTS(NUM_SLOTS), .PATH_LEN(PATH_LEN), .STATE_W(STATE_W)
  ) u_match (
    .claim_tag(claim_tag),
    .decisions(decisions),
    .cur_valid(slot_valid),
    .cur_tag  (slot_tag),
    .cur_path (slot_path),
    .src_hit  (src_hit),
    .new_path (new_path)
  );

  svm_slot_bank #(
    .NUM_SLOTS(NUM_SLOTS), .PATH_LEN(PATH_LEN), .STATE_W(STATE_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (frame_start),
    .update    (stage_take),
    .claim     (claim_vec),
    .claim_tag (claim_tag),
    .src_hit   (src_hit),
    .new_path  (new_path),
    .slot_valid(slot_valid),
    .slot_tag  (slot_tag),
    .slot_path (slot_path)
  );

  svm_s0_read #(
    .NUM_SLOTS(NUM_SLOTS), .PATH_LEN(PATH_LEN), .STATE_W(STATE_W)
  ) u_read (
    .slot_valid(slot_valid),
    .slot_tag  (slot_tag),
    .slot_path (slot_path),
    .hit       (s0_valid),
    .path      (s0_path)
  );

endmodule

// File: rtl/svm_checker.sv
`timescale 1ns/1ps
module svm_checker #(
  parameter int NUM_STATES = 16,
  parameter int NUM_SLOTS  = 8,
  parameter int PATH_LEN   = 16,
  parameter int METRIC_W   = 8,
  parameter int THR_W      = 4,
  parameter int LOAD_W     = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_start,
  input logic                  stage_valid,
  input logic [METRIC_W-1:0]   m0,
  input logic [THR_W-1:0]      thr_active,
  input logic [NUM_STATES-1:0] dropped,
  input logic [NUM_SLOTS-1:0]  claim,
  input logic [PATH_LEN-1:0]   s0_path,
  input logic                  s0_valid,
  input logic [LOAD_W-1:0]     path_loads
);

  p_frame_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (s0_valid && (s0_path == '0) && (path_loads == '0)));

  p_excluded_s0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_valid && !frame_start && (int'(m0) > int'(thr_active))) |=> !s0_valid);

  p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|dropped) |-> (&claim));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_valid || frame_start) |=> (path_loads == '0));

  p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(thr_active));

  p_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && stage_valid) |=> (s0_valid && (path_loads == '0)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_valid && !frame_start) |=> ($stable(s0_path) && $stable(s0_valid)));

endmodule

bind tm_survivor_mem svm_checker #(
  .NUM_STATES(NUM_STATES), .NUM_SLOTS(NUM_SLOTS), .PATH_LEN(PATH_LEN),
  .METRIC_W(METRIC_W), .THR_W(THR_W), .LOAD_W(LOAD_W)
) u_svm_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_start(frame_start),
  .stage_valid(stage_valid),
  .m0         (path_metrics[METRIC_W-1:0]),
  .thr_active (thr_active),
  .dropped    (dropped_vec),
  .claim      (claim_vec),
  .s0_path    (s0_path),
  .s0_valid   (s0_valid),
  .path_loads (path_loads)
);

// File: tb/test_tm_survivor_mem.sv
`timescale 1ns/1ps
module test_tm_survivor_mem;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_start = 1'b0;
  logic         stage_valid = 1'b0;
  logic [3:0]   threshold = 4'd5;
  logic [127:0] path_metrics = '0;
  logic [15:0]  decisions = '0;
  logic [15:0]  s0_path;
  logic         s0_valid;
  logic [3:0]   path_loads;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int cycles   = 0;

  int          met [16];
  logic [15:0] dec_b;
  int          m_thr;
  bit          m_live [16];
  logic [15:0] m_path [16];
  int          m_loads;

  always #2.5 clk = ~clk;

  tm_survivor_mem i_tm_survivor_mem (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .stage_valid(stage_valid),
    .threshold(threshold), .path_metrics(path_metrics), .decisions(decisions),
    .s0_path(s0_path), .s0_valid(s0_valid), .path_loads(path_loads)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_init();
    for (int s = 0; s < 16; s++) begin m_live[s] = 0; m_path[s] = '0; end
    m_live[0] = 1;
    m_loads = 0;
  endtask

  task automatic model_stage();
    bit          nl [16];
    logic [15:0] np [16];
    int          admitted = 0;
    m_loads = 0;
    for (int s = 0; s < 16; s++) begin nl[s] = 0; np[s] = m_path[s]; end
    for (int s = 0; s < 16; s++) begin
      if (met[s] <= m_thr && admitted < 8) begin
        int p = dec_b[s] ? (8 + (s >> 1)) : (s >> 1);
        admitted++;
        if (m_live[p]) begin
          nl[s] = 1;
          np[s] = {m_path[p][14:0], s[0]};
          m_loads++;
        end
      end
    end
    for (int s = 0; s < 16; s++) begin m_live[s] = nl[s]; m_path[s] = np[s]; end
  endtask

  task automatic pack_inputs();
    for (int s = 0; s < 16; s++) path_metrics[s*8 +: 8] = 8'(met[s]);
    decisions = dec_b;
  endtask

  task automatic set_only(input int st, input int mval, input logic [15:0] d);
    for (int s = 0; s < 16; s++) met[s] = 200;
    met[st] = mval;
    dec_b = d;
  endtask

  task automatic compare_model(input string req);
    check({req, " s0_valid"}, 32'(s0_valid), 32'(m_live[0]));
    if (m_live[0]) check({req, " s0_path"}, 32'(s0_path), 32'(m_path[0]));
    check({req, " path_loads"}, 32'(path_loads), 32'(m_loads));
  endtask

  task automatic run_stage(input string req);
    @(negedge clk);
    pack_inputs();
    stage_valid = 1'b1;
    @(negedge clk);
    stage_valid = 1'b0;
    model_stage();
    compare_model(req);
  endtask

  task automatic new_frame(input int thr);
    @(negedge clk);
    threshold = 4'(thr);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    m_thr = thr;
    model_init();
    check("R1 frame s0_valid", 32'(s0_valid), 32'd1);
    check("R1 frame s0_path", 32'(s0_path), 32'd0);
  endtask

  // R1, R8: reset state and default threshold of 5
  task automatic t_reset();
    check("R1 reset s0_valid", 32'(s0_valid), 32'd1);
    check("R1 reset s0_path", 32'(s0_path), 32'd0);
    check("R1 reset path_loads", 32'(path_loads), 32'd0);
    m_thr = 5; model_init();
    threshold = 4'd15;
    set_only(0, 5, 16'h0000);
    run_stage("R8 default threshold");
    check("R8 default loads", 32'(path_loads), 32'd1);
    set_only(0, 6, 16'h0000);
    run_stage("R8 default threshold edge");
    check("R8 default excludes 6", 32'(s0_valid), 32'd0);
  endtask

  // R3: walk 0->1->2->4->8->0 gives path 0x0010
  task automatic t_walk();
    new_frame(5);
    set_only(1, 0, 16'h0000); run_stage("R3 walk1");
    set_only(2, 0, 16'h0000); run_stage("R3 walk2");
    set_only(4, 0, 16'h0000); run_stage("R3 walk3");
    set_only(8, 0, 16'h0000); run_stage("R3 walk4");
    set_only(0, 0, 16'h0001); run_stage("R3 walk5");
    check("R3 walk path", 32'(s0_path), 32'h0010);
    check("R3 walk valid", 32'(s0_valid), 32'd1);
  endtask

  // R2, R5: metric equal to threshold passes, one above fails
  task automatic t_boundary();
    new_frame(7);
    set_only(0, 7, 16'h0000); run_stage("R2 equal");
    check("R2 equal qualifies", 32'(s0_valid), 32'd1);
    set_only(0, 8, 16'h0000); run_stage("R5 above");
    check("R5 excluded s0", 32'(s0_valid), 32'd0);
    check("R5 excluded loads", 32'(path_loads), 32'd0);
  endtask

  // R4: predecessor without a path
  task automatic t_missing();
    new_frame(5);
    set_only(0, 0, 16'h0001); run_stage("R4 missing pred");
    check("R4 s0 invalid", 32'(s0_valid), 32'd0);
  endtask

  // R6: overflow admits ascending states only
  task automatic t_overflow();
    new_frame(5);
    for (int s = 0; s < 16; s++) met[s] = 0;
    dec_b = 16'h0000;
    run_stage("R6 overflow 1");
    check("R6 loads 1", 32'(path_loads), 32'd2);
    run_stage("R6 overflow 2");
    check("R6 loads 2", 32'(path_loads), 32'd4);
    new_frame(5);
    set_only(1, 0, 16'h0000); run_stage("R6 walk1");
    set_only(2, 0, 16'h0000); run_stage("R6 walk2");
    set_only(4, 0, 16'h0000); run_stage("R6 walk3");
    for (int s = 0; s < 16; s++) met[s] = 0;
    dec_b = 16'h0000;
    run_stage("R6 state 8 dropped");
    set_only(0, 0, 16'h0001); run_stage("R6 after drop");
    check("R6 dropped state not revived", 32'(s0_valid), 32'd0);
  endtask

  // R8: threshold latched only at frame start
  task automatic t_thr_latch();
    new_frame(5);
    threshold = 4'd15;
    set_only(0, 10, 16'h0000); run_stage("R8 mid-frame change");
    check("R8 old threshold kept", 32'(s0_valid), 32'd0);
    new_frame(15);
    set_only(0, 10, 16'h0000); run_stage("R8 new threshold");
    check("R8 new threshold used", 32'(s0_valid), 32'd1);
    check("R8 new threshold loads", 32'(path_loads), 32'd1);
  endtask

  // R9: restart wins over a stage in the same cycle
  task automatic t_priority();
    new_frame(5);
    set_only(0, 9, 16'h0000); run_stage("R9 prep");
    @(negedge clk);
    set_only(0, 9, 16'h0000); pack_inputs();
    frame_start = 1'b1; stage_valid = 1'b1; threshold = 4'd5;
    @(negedge clk);
    frame_start = 1'b0; stage_valid = 1'b0;
    model_init();
    check("R9 s0_valid", 32'(s0_valid), 32'd1);
    check("R9 s0_path", 32'(s0_path), 32'd0);
    check("R9 path_loads", 32'(path_loads), 32'd0);
  endtask

  // R10, R7: idle cycles change nothing and report zero loads
  task automatic t_idle();
    new_frame(5);
    set_only(1, 0, 16'h0000); run_stage("R10 prep1");
    set_only(2, 1, 16'h0000); run_stage("R10 prep2");
    set_only(1, 0, 16'h0004); run_stage("R10 prep3");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      for (int s = 0; s < 16; s++) met[s] = 0;
      dec_b = 16'(i * 16'h1357);
      pack_inputs();
    end
    @(negedge clk);
    set_only(1, 0, 16'h0000);
    check("R10 idle path held", 32'(s0_path), 32'(m_path[0]));
    check("R10 idle valid held", 32'(s0_valid), 32'(m_live[0]));
    check("R7 idle loads zero", 32'(path_loads), 32'd0);
  endtask

  // R3, R6, R7: random stages against the model
  task automatic t_random(input int span, input int thr, input int count);
    new_frame(thr);
    for (int n = 0; n < count; n++) begin
      for (int s = 0; s < 16; s++) met[s] = int'($urandom_range(span, 0));
      dec_b = 16'($urandom());
      run_stage("R7 random");
      if ((n % 40) == 39) new_frame(thr);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk();
    t_boundary();
    t_missing();
    t_overflow();
    t_thr_latch();
    t_priority();
    t_idle();
    t_random(9, 5, 200);
    t_random(3, 2, 200);
    t_random(15, 15, 100);
    finish_run();
  end

endmodule